// File: doc/BRIEF.md
# Occupancy-Driven Frequency State Selector

This block watches how many packet headers are waiting in a header buffer and chooses one of `NUM_STATES` rate states for a downstream classification engine. The fill level is the difference between the buffer's write and read pointers. Each pointer carries one extra wrap bit, so a full buffer and an empty buffer give different results. State `i` runs the engine at the top rate divided by `2^(NUM_STATES-1-i)`. The rate is delivered as a one-cycle enable strobe taken from the reference clock, so the whole design stays on a single clock.

Each state except the highest has a cumulative threshold register. The slice a state owns is its threshold minus the previous one, and the highest state owns whatever remains up to the buffer depth. A state with an empty slice is unused.

When the fill level rises above the current state's threshold, the selector moves to the next used state above it. It falls back only when the buffer is completely empty, and then it goes straight to the lowest used state. Before every change it raises an idle request and waits for the engine's acknowledge.

Top module: `freqsel_top`

## Requirements
- R1: The fill level is `wrPtr - rdPtr` taken modulo `2^(log2(BUF_DEPTH)+1)`. A difference of `BUF_DEPTH` is a full buffer and is never read as empty, including when the pointers have wrapped.
- R2: After reset `stateIdx` is 0, `idleReq` is 0, and every threshold register holds `BUF_DEPTH`, so state 0 owns the whole buffer.
- R3: In state `i` the strobe `rateStrobe` pulses once every `2^(NUM_STATES-1-i)` cycles. Its divider restarts at every state change, so the first pulse comes `2^(NUM_STATES-1-i)-1` cycles after the change. In the top state the strobe is high on every cycle.
- R4: When the fill level is above the current state's threshold, the selector requests the next higher used state and skips any states with a zero slice.
- R5: A fill level equal to the current state's threshold causes no change.
- R6: A non-zero fill level never lowers the state. A fill level of zero in any state other than the lowest used state requests a direct move to the lowest used state.
- R7: A state change happens only on the clock edge where `idleReq` is high and `idleAck` is high. While `idleReq` is high, `stateIdx` holds its value and `rateStrobe` stays low.
- R8: If one state owns all `BUF_DEPTH` slots, the state never changes, whatever the fill level.
- R9: A write with `cfgWrEn` high updates threshold `cfgIdx` at the next edge, at any time, and the new value governs the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrPtr | input | log2(BUF_DEPTH)+1 | Header buffer write pointer with wrap bit |
| rdPtr | input | log2(BUF_DEPTH)+1 | Header buffer read pointer with wrap bit |
| cfgWrEn | input | 1 | Threshold write enable |
| cfgIdx | input | clog2(NUM_STATES) | State whose threshold is written |
| cfgThr | input | log2(BUF_DEPTH)+1 | Cumulative threshold value |
| idleAck | input | 1 | Engine reports it is idle |
| stateIdx | output | clog2(NUM_STATES) | Selected rate state |
| rateStrobe | output | 1 | Clock enable at the selected rate |
| idleReq | output | 1 | Request for the engine to go idle before a change |

## Verification
The bench uses the default build: ten states and a sixteen-entry buffer with five-bit pointers. This lets it drive a genuinely full buffer and pointers that wrap past 31. Ten states make the slowest divider 512 cycles long, short enough to measure a full period. A layout that leaves states 5 and 6 empty shows skipping, and the top state shows the every-cycle strobe. Holding off the acknowledge for several cycles shows that the state and the strobe stay frozen during the handshake.

// File: rtl/freqsel_pkg.sv
package freqsel_pkg;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_WAIT = 1'b1
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic commit;   // load pending state, restart divider
    logic holdOff;  // handshake in progress, mute rate strobe
  } ctlStrobe_t;

endpackage

// File: rtl/freqsel_datapath.sv
module freqsel_datapath
  import freqsel_pkg::*;
#(
  parameter int NUM_STATES = 10,
  parameter int BUF_DEPTH  = 16,
  localparam int PTR_W = $clog2(BUF_DEPTH) + 1,
  localparam int IDX_W = $clog2(NUM_STATES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [PTR_W-1:0] cfgThr,
  input  ctlStrobe_t       ctl,
  input  logic [IDX_W-1:0] pendState,
  output logic [IDX_W-1:0] curState,
  output logic             wantUp,
  output logic             wantDown,
  output logic [IDX_W-1:0] upTarget,
  output logic [IDX_W-1:0] lowIdx,
  output logic             rateStrobe
);

  localparam int TOP_IDX = NUM_STATES - 1;
  localparam int DIV_W   = (NUM_STATES > 1) ? NUM_STATES - 1 : 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(BUF_DEPTH);

  logic [PTR_W-1:0] thrReg [NUM_STATES-1];
  logic [PTR_W-1:0] thrAll [NUM_STATES];
  logic [NUM_STATES-1:0] used;
  logic [PTR_W-1:0] occ;
  logic foundUp;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   divSpan;
  logic [DIV_W-1:0] divLast;

  // Threshold registers, writable at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_STATES - 1; k++) thrReg[k] <= FULL;
    end else if (cfgWrEn) begin
      for (int k = 0; k < NUM_STATES - 1; k++)
        if (cfgIdx == IDX_W'(k)) thrReg[k] <= cfgThr;
    end
  end

  // Slice ownership: a state is used when its slice is non-empty
  for (genvar g = 0; g < NUM_STATES; g++) begin : g_slice
    if (g == TOP_IDX) begin : g_top
      assign thrAll[g] = FULL;
      if (g == 0) begin : g_only
        assign used[g] = 1'b1;
      end else begin : g_rest
        assign used[g] = thrReg[g-1] != FULL;
      end
    end else if (g == 0) begin : g_first
      assign thrAll[g] = thrReg[g];
      assign used[g]   = thrReg[g] != '0;
    end else begin : g_mid
      assign thrAll[g] = thrReg[g];
      assign used[g]   = thrReg[g] != thrReg[g-1];
    end
  end

  assign occ = wrPtr - rdPtr;

  // Lowest used state and nearest used state above the current one
  always_comb begin
    lowIdx   = '0;
    upTarget = curState;
    foundUp  = 1'b0;
    for (int k = NUM_STATES - 1; k >= 0; k--) begin
      if (used[k]) begin
        lowIdx = IDX_W'(k);
        if (IDX_W'(k) > curState) begin
          upTarget = IDX_W'(k);
          foundUp  = 1'b1;
        end
      end
    end
  end

  assign wantUp   = (curState != IDX_W'(TOP_IDX)) && (occ > thrAll[curState]) && foundUp;
  assign wantDown = (occ == '0) && (curState != lowIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curState <= '0;
    else if (ctl.commit) curState <= pendState;
  end

  // Clock-enable divider
  assign divSpan = (DIV_W+1)'(1) << (IDX_W'(TOP_IDX) - curState);
  assign divLast = DIV_W'(divSpan - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (ctl.commit)       divCnt <= '0;
    else if (divCnt >= divLast) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end

  assign rateStrobe = (divCnt == divLast) && !ctl.holdOff;

endmodule

// File: rtl/freqsel_ctrl.sv
module freqsel_ctrl
  import freqsel_pkg::*;
#(
  parameter int NUM_STATES = 10,
  localparam int IDX_W = $clog2(NUM_STATES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wantUp,
  input  logic             wantDown,
  input  logic [IDX_W-1:0] upTarget,
  input  logic [IDX_W-1:0] lowIdx,
  input  logic             idleAck,
  output ctlStrobe_t       ctl,
  output logic [IDX_W-1:0] pendState,
  output logic             idleReq
);

  phase_t phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_RUN;
      pendState <= '0;
    end else begin
      case (phase)
        PH_RUN: begin
          if (wantDown) begin
            pendState <= lowIdx;
            phase     <= PH_WAIT;
          end else if (wantUp) begin
            pendState <= upTarget;
            phase     <= PH_WAIT;
          end
        end
        default: begin
          if (idleAck) phase <= PH_RUN;
        end
      endcase
    end
  end

  assign idleReq     = (phase == PH_WAIT);
  assign ctl.holdOff = (phase == PH_WAIT);
  assign ctl.commit  = (phase == PH_WAIT) && idleAck;

endmodule

// File: rtl/freqsel_top.sv
module freqsel_top
  import freqsel_pkg::*;
#(
  parameter int NUM_STATES = 10,
  parameter int BUF_DEPTH  = 16,
  localparam int PTR_W = $clog2(BUF_DEPTH) + 1,
  localparam int IDX_W = $clog2(NUM_STATES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [PTR_W-1:0] cfgThr,
  input  logic             idleAck,
  output logic [IDX_W-1:0] stateIdx,
  output logic             rateStrobe,
  output logic             idleReq
);

  ctlStrobe_t       ctl;
  logic [IDX_W-1:0] pendState;
  logic             wantUp;
  logic             wantDown;
  logic [IDX_W-1:0] upTarget;
  logic [IDX_W-1:0] lowIdx;

  freqsel_datapath #(.NUM_STATES(NUM_STATES), .BUF_DEPTH(BUF_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgThr(cfgThr),
    .ctl(ctl), .pendState(pendState), .curState(stateIdx),
    .wantUp(wantUp), .wantDown(wantDown), .upTarget(upTarget),
    .lowIdx(lowIdx), .rateStrobe(rateStrobe)
  );

  freqsel_ctrl #(.NUM_STATES(NUM_STATES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wantUp(wantUp), .wantDown(wantDown),
    .upTarget(upTarget), .lowIdx(lowIdx), .idleAck(idleAck),
    .ctl(ctl), .pendState(pendState), .idleReq(idleReq)
  );

endmodule

// File: rtl/freqsel_checker.sv
module freqsel_checker #(
  parameter int NUM_STATES = 10,
  localparam int IDX_W = $clog2(NUM_STATES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             idleAck,
  input logic [IDX_W-1:0] stateIdx,
  input logic             rateStrobe,
  input logic             idleReq
);

  AST_CHANGE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stateIdx) |-> ($past(idleReq) && $past(idleAck))); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (idleReq && !idleAck) |=> (idleReq && $stable(stateIdx))); // R7

  AST_MUTE_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |-> !rateStrobe); // R7

  AST_TOP_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateIdx == IDX_W'(NUM_STATES - 1) && !idleReq) |-> rateStrobe); // R3

  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (rateStrobe && stateIdx != IDX_W'(NUM_STATES - 1)) |=> !rateStrobe); // R3

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stateIdx < IDX_W'(NUM_STATES)); // R4

endmodule

bind freqsel_top freqsel_checker #(.NUM_STATES(NUM_STATES)) chk_i (
  .clk(clk), .rstN(rstN), .idleAck(idleAck), .stateIdx(stateIdx),
  .rateStrobe(rateStrobe), .idleReq(idleReq)
);

// File: tb/freqsel_top_tb_top.sv
module freqsel_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] wrPtr = '0;
  logic [4:0] rdPtr = '0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgIdx = '0;
  logic [4:0] cfgThr = '0;
  logic       idleAck = 1'b0;
  logic [3:0] stateIdx;
  logic       rateStrobe;
  logic       idleReq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  freqsel_top dut_i (
    .clk(clk), .rstN(rstN), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgThr(cfgThr), .idleAck(idleAck),
    .stateIdx(stateIdx), .rateStrobe(rateStrobe), .idleReq(idleReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setPtrs(input int w, input int r);
    wrPtr = 5'(w);
    rdPtr = 5'(r);
  endtask

  task automatic cfgWrite(input int idx, input int val);
    cfgWrEn = 1'b1; cfgIdx = 4'(idx); cfgThr = 5'(val);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Acknowledge a pending request and check the resulting state
  task automatic ackAndCheck(input string req, input int expState);
    chk({req, " idleReq before ack"}, int'(idleReq), 1);
    idleAck = 1'b1;
    @(negedge clk);
    idleAck = 1'b0;
    chk({req, " state after ack"}, int'(stateIdx), expState);
    chk({req, " idleReq dropped"}, int'(idleReq), 0);
  endtask

  // Cycles from the commit sample to the first strobe, then the gap to the next
  task automatic measureStrobe(input string req, input int period);
    int first = -1;
    int gap = -1;
    for (int i = 0; i < 600; i++) begin
      if (rateStrobe) begin first = i; break; end
      @(negedge clk);
    end
    chk({req, " first strobe offset"}, first, period - 1);
    for (int i = 1; i < 600; i++) begin
      @(negedge clk);
      if (rateStrobe) begin gap = i; break; end
    end
    chk({req, " strobe period"}, gap, period);
  endtask

  task automatic testReset();
    chk("R2 reset state", int'(stateIdx), 0);
    chk("R2 reset idleReq", int'(idleReq), 0);
  endtask

  // Default layout: state 0 owns all slots
  task automatic testFixedRate();
    int gap = -1;
    setPtrs(16, 0);
    repeat (6) @(negedge clk);
    chk("R8 full buffer keeps state", int'(stateIdx), 0);
    chk("R8 R1 no request at full", int'(idleReq), 0);
    setPtrs(4, 20);
    repeat (3) @(negedge clk);
    chk("R8 R1 wrapped full keeps state", int'(stateIdx), 0);
    for (int i = 0; i < 600; i++) begin
      if (rateStrobe) break;
      @(negedge clk);
    end
    for (int i = 1; i < 600; i++) begin
      @(negedge clk);
      if (rateStrobe) begin gap = i; break; end
    end
    chk("R3 slowest strobe period", gap, 512);
    setPtrs(0, 0);
    @(negedge clk);
  endtask

  // Slices: S4=4, S7=4, S8=4, S9=4. Descending writes keep state 0 lowest until the last one.
  task automatic testConfigure();
    cfgWrite(8, 12);
    cfgWrite(7, 8);
    cfgWrite(6, 4);
    cfgWrite(5, 4);
    cfgWrite(4, 4);
    cfgWrite(3, 0);
    cfgWrite(2, 0);
    cfgWrite(1, 0);
    chk("R9 no request before last write", int'(idleReq), 0);
    cfgWrite(0, 0);
    @(negedge clk);
    ackAndCheck("R6 R9 empty moves to lowest used", 4);
    measureStrobe("R3 state4", 32);
  endtask

  task automatic testStepUp();
    setPtrs(4, 0);
    repeat (3) @(negedge clk);
    chk("R5 equal to threshold holds", int'(idleReq), 0);
    chk("R5 state held", int'(stateIdx), 4);
    setPtrs(3, 30);  // wrapped pointers, fill 5
    @(negedge clk);
    chk("R1 R4 wrapped fill requests", int'(idleReq), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 state held without ack", int'(stateIdx), 4);
      chk("R7 strobe muted", int'(rateStrobe), 0);
    end
    ackAndCheck("R4 skip unused to state7", 7);
    setPtrs(3, 0);
    repeat (3) @(negedge clk);
    chk("R6 nonzero below keeps state", int'(stateIdx), 7);
    chk("R6 no request", int'(idleReq), 0);
    setPtrs(6, 0);
    repeat (2) @(negedge clk);
    chk("R9 below old threshold", int'(idleReq), 0);
    cfgWrite(7, 5);
    @(negedge clk);
    ackAndCheck("R9 lowered threshold steps to state8", 8);
    measureStrobe("R3 state8", 2);
    setPtrs(13, 0);
    @(negedge clk);
    ackAndCheck("R4 step to top state", 9);
    for (int i = 0; i < 4; i++) begin
      chk("R3 top strobe every cycle", int'(rateStrobe), 1);
      @(negedge clk);
    end
  endtask

  task automatic testDrop();
    setPtrs(16, 0);
    repeat (3) @(negedge clk);
    chk("R4 top stays at full", int'(stateIdx), 9);
    setPtrs(1, 0);
    repeat (3) @(negedge clk);
    chk("R6 one entry keeps top", int'(stateIdx), 9);
    setPtrs(0, 0);
    @(negedge clk);
    ackAndCheck("R6 empty drops to lowest used", 4);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFixedRate();
    testConfigure();
    testStepUp();
    testDrop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule